// File: doc/BRIEF.md
# Time-Slotted Router Crossbar

This block is the switching core of a circuit-switched on-chip router that shares its links by time division. It has a fixed number of input lanes and the same number of output lanes. A free-running slot counter divides time into slots of two words each. For every output and every slot, a local schedule entry either names the input lane that feeds that output or marks the output idle. Words are never inspected: the route a word takes depends only on the cycle in which it arrives and on the local schedule. There is no header and no back-pressure. Each lane carries a valid flag, a data word and a small credit field. The credit field is switched exactly like the data, so the end-to-end flow-control returns travel on the same schedule.

When several outputs name the same input in the same slot, one incoming stream is copied to all of them. This is how multicast trees are built. A configuration decoder outside this block writes schedule entries through a one-entry-per-cycle write port. A write only changes routing from the next slot boundary on, so the slot in progress is never disturbed. A word spends exactly two cycles in the block: one register models the link and one the crossbar.

Top module: `tdm_xbar_router`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every output lane shows valid 0, data 0 and credit 0, `slot_now` is 0 and every schedule entry is idle.
- R2: `slot_now` holds each value for exactly two cycles and then steps by one. After 7 it wraps to 0. The first slot after reset starts in the first cycle after reset is released.
- R3: A word driven on an input in cycle c is seen on its selected outputs in cycle c+2. The valid flag travels with the word.
- R4: The schedule entry that routes a word is the one for the output and the slot in force during cycle c+1, when the word sits in the link register. The entry's source field (0 to 3) chooses the input lane.
- R5: Two or more outputs whose entries name the same input in the same slot all carry that input's word in the same cycle.
- R6: An entry whose enable bit is 0 (idle) drives its output to data 0, credit 0 and valid 0. Writing an entry with `cfg_wr_enable` = 0 makes it idle.
- R7: The credit field of the chosen input is forwarded unchanged, in the same cycle as the data.
- R8: Forwarding is blind. A routed input word whose valid flag is low still has its data and credit forwarded, with valid low.
- R9: A write accepted in any cycle of slot s has no effect on routing during slot s. It governs the addressed entry from the first cycle of slot s+1 on, including when it is written in the last cycle of s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NUM_PORTS | Valid flag per input lane |
| in_data | input | NUM_PORTS*DATA_W | Data word per input lane, lane 0 in the low bits |
| in_credit | input | NUM_PORTS*CREDIT_W | Credit field per input lane |
| out_valid | output | NUM_PORTS | Valid flag per output lane |
| out_data | output | NUM_PORTS*DATA_W | Data word per output lane |
| out_credit | output | NUM_PORTS*CREDIT_W | Credit field per output lane |
| cfg_wr_en | input | 1 | Write one schedule entry this cycle |
| cfg_wr_out | input | log2(NUM_PORTS) | Output lane of the entry written |
| cfg_wr_slot | input | log2(SLOTS) | Slot of the entry written |
| cfg_wr_enable | input | 1 | 1 routes from `cfg_wr_src`, 0 makes the entry idle |
| cfg_wr_src | input | log2(NUM_PORTS) | Input lane named by the entry |
| slot_now | output | log2(SLOTS) | Slot currently in force |

## Verification
The bench goes after the moment a schedule write becomes active. It writes in the last cycle of a slot and in the middle of one, and it compares outputs while a write is still pending. A design that applied writes at once, or one slot late, would route words of the current slot through the new entry, or would skip the first slot that should use it. It builds multicast groups, including one on the slot that wraps from 7 to 0. A mux shared wrongly between outputs, or a slot counter that is off by one at the wrap, would then drop a copy. It sends words with valid low and idle entries with random data still present on the inputs. A design that gated data on valid, or left stale data on idle outputs, would show nonzero words where zero or pass-through is required.

// File: rtl/tdm_xbar_pkg.sv
// Package: shared helpers and encodings for the time-slotted router crossbar.
// Assumes nothing beyond standard elaboration-time constant functions.
package tdm_xbar_pkg;

    // Width of an index able to address n items (at least one bit).
    function automatic int sel_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Meaning of the enable bit held in each schedule entry.
    typedef enum logic {
        ENTRY_IDLE  = 1'b0,
        ENTRY_ROUTE = 1'b1
    } entry_mode_e;

endpackage

// File: rtl/tdm_slot_timer.sv
// Module: tdm_slot_timer
// Counts words within a slot and slots within the schedule wheel.
// Assumes WORDS_PER_SLOT >= 1 and SLOTS >= 1. The counter restarts at slot 0,
// word 0 on reset. boundary_o is high in the last word of every slot.
module tdm_slot_timer #(
    parameter int SLOTS          = 8,
    parameter int WORDS_PER_SLOT = 2,
    localparam int SLOT_W  = tdm_xbar_pkg::sel_width(SLOTS),
    localparam int PHASE_W = tdm_xbar_pkg::sel_width(WORDS_PER_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              boundary_o
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(WORDS_PER_SLOT - 1);
    localparam logic [SLOT_W-1:0]  LAST_SLOT  = SLOT_W'(SLOTS - 1);

    logic [PHASE_W-1:0] phase_q;
    logic [SLOT_W-1:0]  slot_q;

    // Last word of the slot: the next edge starts a new slot.
    assign boundary_o = (phase_q == LAST_PHASE);
    assign slot_o     = slot_q;

    // Word counter within the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= '0;
        else if (boundary_o) phase_q <= '0;
        else                 phase_q <= phase_q + 1'b1;
    end

    // Slot counter, stepping at each boundary and wrapping at the wheel size.
    always_ff @(posedge clk) begin
        if (!rst_n)                 slot_q <= '0;
        else if (boundary_o) begin
            if (slot_q == LAST_SLOT) slot_q <= '0;
            else                     slot_q <= slot_q + 1'b1;
        end
    end

endmodule

// File: rtl/tdm_slot_table.sv
// Module: tdm_slot_table
// Holds one schedule entry per output and slot: an enable bit and a source lane.
// Writes land in a shadow copy at once. The active copy, which drives routing,
// takes over the shadow contents (including a write in that same cycle) at the
// edge that closes a slot. Assumes at most one write per cycle.
module tdm_slot_table #(
    parameter int NUM_PORTS = 4,
    parameter int SLOTS     = 8,
    localparam int PORT_W  = tdm_xbar_pkg::sel_width(NUM_PORTS),
    localparam int SLOT_W  = tdm_xbar_pkg::sel_width(SLOTS),
    localparam int ENTRY_W = PORT_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        boundary_i,
    input  logic [SLOT_W-1:0]           slot_i,
    input  logic                        wr_en_i,
    input  logic [PORT_W-1:0]           wr_out_i,
    input  logic [SLOT_W-1:0]           wr_slot_i,
    input  logic                        wr_enable_i,
    input  logic [PORT_W-1:0]           wr_src_i,
    output logic [NUM_PORTS-1:0]        sel_en_o,
    output logic [NUM_PORTS*PORT_W-1:0] sel_port_o
);

    logic [ENTRY_W-1:0] shadow_q [NUM_PORTS][SLOTS];
    logic [ENTRY_W-1:0] active_q [NUM_PORTS][SLOTS];
    logic [ENTRY_W-1:0] wr_entry;

    // Entry image carried by the write port.
    assign wr_entry = {wr_enable_i, wr_src_i};

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic               hit;
            logic [ENTRY_W-1:0] shadow_d;

            // This entry is addressed by the current write.
            assign hit      = wr_en_i && (int'(wr_out_i) == o) && (int'(wr_slot_i) == s);
            assign shadow_d = hit ? wr_entry : shadow_q[o][s];

            // Shadow copy follows writes immediately.
            always_ff @(posedge clk) begin
                if (!rst_n) shadow_q[o][s] <= '0;
                else        shadow_q[o][s] <= shadow_d;
            end

            // Active copy refreshed only when a slot closes.
            always_ff @(posedge clk) begin
                if (!rst_n)          active_q[o][s] <= '0;
                else if (boundary_i) active_q[o][s] <= shadow_d;
            end
        end

        // Read the entry governing the slot in force.
        always_comb begin
            sel_en_o[o]                    = active_q[o][slot_i][PORT_W];
            sel_port_o[o*PORT_W +: PORT_W] = active_q[o][slot_i][PORT_W-1:0];
        end
    end

endmodule

// File: rtl/tdm_link_stage.sv
// Module: tdm_link_stage
// One register per input lane, standing for the link hop into the router.
// Assumes lanes are packed side by side, lane 0 in the low bits.
module tdm_link_stage #(
    parameter int NUM_PORTS = 4,
    parameter int LANE_W    = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*LANE_W-1:0] lanes_i,
    output logic [NUM_PORTS*LANE_W-1:0] lanes_o
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        // Capture the incoming lane word every cycle, without looking at it.
        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lanes_i[p*LANE_W +: LANE_W];
        end

        assign lanes_o[p*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/tdm_xbar_mux.sv
// Module: tdm_xbar_mux
// Registered crossbar: each output picks one input lane or forces zero.
// Assumes the selection is valid for the cycle in which the lanes are present.
// A source index beyond the lane count is treated as idle.
module tdm_xbar_mux #(
    parameter int NUM_PORTS = 4,
    parameter int LANE_W    = 20,
    localparam int PORT_W = tdm_xbar_pkg::sel_width(NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*LANE_W-1:0] lanes_i,
    input  logic [NUM_PORTS-1:0]        sel_en_i,
    input  logic [NUM_PORTS*PORT_W-1:0] sel_port_i,
    output logic [NUM_PORTS*LANE_W-1:0] lanes_o
);

    import tdm_xbar_pkg::*;

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        logic [PORT_W-1:0] pick;
        logic              route;
        logic [LANE_W-1:0] out_q;

        assign pick  = sel_port_i[o*PORT_W +: PORT_W];
        // Route only for an enabled entry naming an existing lane.
        assign route = (sel_en_i[o] == ENTRY_ROUTE) && (int'(pick) < NUM_PORTS);

        // Crossbar register: chosen lane or all zero.
        always_ff @(posedge clk) begin
            if (!rst_n)     out_q <= '0;
            else if (route) out_q <= lanes_i[int'(pick)*LANE_W +: LANE_W];
            else            out_q <= '0;
        end

        assign lanes_o[o*LANE_W +: LANE_W] = out_q;
    end

endmodule

// File: rtl/tdm_xbar_router.sv
// Module: tdm_xbar_router
// Top of the time-slotted router crossbar. Each lane bundles {valid, credit, data}.
// A word spends one cycle in the link stage and one in the crossbar stage. The
// crossbar follows the schedule entry of the slot in force while the word is in
// the link stage. Assumes the configuration writer issues at most one write per cycle.
module tdm_xbar_router #(
    parameter int NUM_PORTS      = 4,
    parameter int DATA_W         = 16,
    parameter int CREDIT_W       = 3,
    parameter int SLOTS          = 8,
    parameter int WORDS_PER_SLOT = 2,
    localparam int PORT_W = tdm_xbar_pkg::sel_width(NUM_PORTS),
    localparam int SLOT_W = tdm_xbar_pkg::sel_width(SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          in_valid,
    input  logic [NUM_PORTS*DATA_W-1:0]   in_data,
    input  logic [NUM_PORTS*CREDIT_W-1:0] in_credit,
    output logic [NUM_PORTS-1:0]          out_valid,
    output logic [NUM_PORTS*DATA_W-1:0]   out_data,
    output logic [NUM_PORTS*CREDIT_W-1:0] out_credit,
    input  logic                          cfg_wr_en,
    input  logic [PORT_W-1:0]             cfg_wr_out,
    input  logic [SLOT_W-1:0]             cfg_wr_slot,
    input  logic                          cfg_wr_enable,
    input  logic [PORT_W-1:0]             cfg_wr_src,
    output logic [SLOT_W-1:0]             slot_now
);

    localparam int LANE_W = 1 + CREDIT_W + DATA_W;

    logic [NUM_PORTS*LANE_W-1:0] in_lanes;
    logic [NUM_PORTS*LANE_W-1:0] link_lanes;
    logic [NUM_PORTS*LANE_W-1:0] out_lanes;
    logic [NUM_PORTS-1:0]        sel_en;
    logic [NUM_PORTS*PORT_W-1:0] sel_port;
    logic                        boundary;

    // Pack and unpack the lane bundles.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pack
        assign in_lanes[p*LANE_W +: LANE_W] =
            {in_valid[p], in_credit[p*CREDIT_W +: CREDIT_W], in_data[p*DATA_W +: DATA_W]};
        assign out_valid[p]                      = out_lanes[p*LANE_W + LANE_W - 1];
        assign out_credit[p*CREDIT_W +: CREDIT_W] = out_lanes[p*LANE_W + DATA_W +: CREDIT_W];
        assign out_data[p*DATA_W +: DATA_W]       = out_lanes[p*LANE_W +: DATA_W];
    end

    tdm_slot_timer #(
        .SLOTS          (SLOTS),
        .WORDS_PER_SLOT (WORDS_PER_SLOT)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_o     (slot_now),
        .boundary_o (boundary)
    );

    tdm_slot_table #(
        .NUM_PORTS (NUM_PORTS),
        .SLOTS     (SLOTS)
    ) table_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary_i  (boundary),
        .slot_i      (slot_now),
        .wr_en_i     (cfg_wr_en),
        .wr_out_i    (cfg_wr_out),
        .wr_slot_i   (cfg_wr_slot),
        .wr_enable_i (cfg_wr_enable),
        .wr_src_i    (cfg_wr_src),
        .sel_en_o    (sel_en),
        .sel_port_o  (sel_port)
    );

    tdm_link_stage #(
        .NUM_PORTS (NUM_PORTS),
        .LANE_W    (LANE_W)
    ) link_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lanes_i (in_lanes),
        .lanes_o (link_lanes)
    );

    tdm_xbar_mux #(
        .NUM_PORTS (NUM_PORTS),
        .LANE_W    (LANE_W)
    ) mux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lanes_i    (link_lanes),
        .sel_en_i   (sel_en),
        .sel_port_i (sel_port),
        .lanes_o    (out_lanes)
    );

endmodule

// File: rtl/tdm_xbar_router_checker.sv
// Module: tdm_xbar_router_checker
// Property checks on the router's ports, attached by bind. It keeps its own
// two-deep copy of the input lanes so it can relate outputs to past inputs.
module tdm_xbar_router_checker #(
    parameter int NUM_PORTS      = 4,
    parameter int DATA_W         = 16,
    parameter int CREDIT_W       = 3,
    parameter int SLOTS          = 8,
    parameter int WORDS_PER_SLOT = 2,
    localparam int SLOT_W = tdm_xbar_pkg::sel_width(SLOTS),
    localparam int LANE_W = 1 + CREDIT_W + DATA_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_PORTS-1:0]          in_valid,
    input logic [NUM_PORTS*DATA_W-1:0]   in_data,
    input logic [NUM_PORTS*CREDIT_W-1:0] in_credit,
    input logic [NUM_PORTS-1:0]          out_valid,
    input logic [NUM_PORTS*DATA_W-1:0]   out_data,
    input logic [NUM_PORTS*CREDIT_W-1:0] out_credit,
    input logic [SLOT_W-1:0]             slot_now
);

    logic [NUM_PORTS*LANE_W-1:0] in_lanes, d1_q, d2_q;
    logic [NUM_PORTS*LANE_W-1:0] out_lanes;
    logic [1:0]                  cyc_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pack
        assign in_lanes[p*LANE_W +: LANE_W] =
            {in_valid[p], in_credit[p*CREDIT_W +: CREDIT_W], in_data[p*DATA_W +: DATA_W]};
        assign out_lanes[p*LANE_W +: LANE_W] =
            {out_valid[p], out_credit[p*CREDIT_W +: CREDIT_W], out_data[p*DATA_W +: DATA_W]};
    end

    // Two-cycle history of the inputs and a saturating count of cycles out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d1_q  <= '0;
            d2_q  <= '0;
            cyc_q <= '0;
        end else begin
            d1_q  <= in_lanes;
            d2_q  <= d1_q;
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 1'b1;
        end
    end

    // True when w is zero or equals one of the lanes in src.
    function automatic logic word_from(input logic [LANE_W-1:0] w,
                                       input logic [NUM_PORTS*LANE_W-1:0] src);
        logic ok;
        ok = (w == '0);
        for (int p = 0; p < NUM_PORTS; p++)
            if (w == src[p*LANE_W +: LANE_W]) ok = 1'b1;
        return ok;
    endfunction

    // R1: reset clears every output lane.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && out_data == '0 && out_credit == '0));

    // R2: a slot change is always a single step, wrapping at the wheel size.
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != 2'd0 && slot_now != $past(slot_now)) |->
        (int'(slot_now) == ((int'($past(slot_now)) == SLOTS - 1) ? 0 : int'($past(slot_now)) + 1)));

    // R2: a new slot value is held for at least a second cycle.
    if (WORDS_PER_SLOT > 1) begin : g_dwell
        assert_slot_dwell_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_q >= 2'd2 && slot_now != $past(slot_now)) |=> $stable(slot_now));
    end

    // R3: an output can only be valid if some input was valid two cycles earlier.
    assert_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> (|(d2_q & {NUM_PORTS{1'b1, {(LANE_W-1){1'b0}}}})));

    // R4 / R6: every output lane is zero or an exact copy of an input lane from two cycles earlier.
    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_src
        assert_word_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
            word_from(out_lanes[o*LANE_W +: LANE_W], d2_q));
    end

endmodule

bind tdm_xbar_router tdm_xbar_router_checker #(
    .NUM_PORTS      (NUM_PORTS),
    .DATA_W         (DATA_W),
    .CREDIT_W       (CREDIT_W),
    .SLOTS          (SLOTS),
    .WORDS_PER_SLOT (WORDS_PER_SLOT)
) checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_credit  (in_credit),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_credit (out_credit),
    .slot_now   (slot_now)
);

// File: tb/tdm_xbar_router_tb.sv
`timescale 1ns/1ps
// Bench: random lane traffic and schedule writes mixed with directed writes at
// slot edges, checked against a cycle model computed from the requirements.
module tdm_xbar_router_tb_top;

    localparam int NP   = 4;
    localparam int DW   = 16;
    localparam int CW   = 3;
    localparam int NS   = 8;
    localparam int NCYC = 3000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP*DW-1:0] in_data = '0;
    logic [NP*CW-1:0] in_credit = '0;
    logic [NP-1:0]   out_valid;
    logic [NP*DW-1:0] out_data;
    logic [NP*CW-1:0] out_credit;
    logic            cfg_wr_en = 1'b0;
    logic [1:0]      cfg_wr_out = '0;
    logic [2:0]      cfg_wr_slot = '0;
    logic            cfg_wr_enable = 1'b0;
    logic [1:0]      cfg_wr_src = '0;
    logic [2:0]      slot_now;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // Model state: shadow and active schedule, previous inputs, expected outputs.
    bit       sh_en [NP][NS];
    int       sh_src[NP][NS];
    bit       ac_en [NP][NS];
    int       ac_src[NP][NS];
    bit       pv_v  [NP];
    bit [DW-1:0] pv_d[NP];
    bit [CW-1:0] pv_c[NP];
    bit       ex_v  [NP];
    bit [DW-1:0] ex_d[NP];
    bit [CW-1:0] ex_c[NP];
    string    ex_tag[NP];

    always #4 clk = ~clk;

    tdm_xbar_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_credit(in_credit),
        .out_valid(out_valid), .out_data(out_data), .out_credit(out_credit),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_out(cfg_wr_out), .cfg_wr_slot(cfg_wr_slot),
        .cfg_wr_enable(cfg_wr_enable), .cfg_wr_src(cfg_wr_src),
        .slot_now(slot_now)
    );

    function automatic int slot_of(input int c);
        return (c / 2) % NS;
    endfunction

    task automatic check(input string req, input int lane, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s lane %0d: got %0h expected %0h", req, lane, got, exp);
        end
    endtask

    task automatic compare_outputs(input int c);
        for (int o = 0; o < NP; o++) begin
            check("R3", o, int'(out_valid[o]), int'(ex_v[o]));
            check(ex_tag[o], o, int'(out_data[o*DW +: DW]), int'(ex_d[o]));
            check("R7", o, int'(out_credit[o*CW +: CW]), int'(ex_c[o]));
        end
        check("R2", c, int'(slot_now), slot_of(c));
    endtask

    // Schedule write chosen for cycle c: directed early, random later.
    task automatic pick_write(input int c, output bit en, output int o, output int s,
                              output bit ena, output int src);
        en = 1'b0; o = 0; s = 0; ena = 1'b0; src = 0;
        if (c == 1)                 begin en = 1; o = 0; s = 1; ena = 1; src = 3; end // R9 last word of slot 0
        else if (c == 4)            begin en = 1; o = 1; s = 2; ena = 1; src = 0; end // R9 written inside slot 2
        else if (c >= 6 && c <= 9)  begin en = 1; o = c - 6; s = 5; ena = 1; src = 2; end // R5 four-way multicast
        else if (c == 20)           begin en = 1; o = 0; s = 1; ena = 0; src = 3; end // R6 disable entry
        else if (c >= 22 && c <= 23) begin en = 1; o = c - 21; s = 7; ena = 1; src = 1; end // R5 on the wrap slot
        else if (c == 24)           begin en = 1; o = 3; s = 0; ena = 1; src = 1; end
        else if (c >= 40 && $urandom_range(3) == 0) begin
            en = 1; o = $urandom_range(NP-1); s = $urandom_range(NS-1);
            ena = ($urandom_range(3) != 0); src = $urandom_range(NP-1);
        end
    endtask

    initial begin
        bit we, wena;
        int wo, ws, wsrc;
        void'($urandom(32'd7331));
        for (int o = 0; o < NP; o++) begin
            for (int s = 0; s < NS; s++) begin
                sh_en[o][s] = 0; sh_src[o][s] = 0; ac_en[o][s] = 0; ac_src[o][s] = 0;
            end
            pv_v[o] = 0; pv_d[o] = '0; pv_c[o] = '0;
            ex_v[o] = 0; ex_d[o] = '0; ex_c[o] = '0; ex_tag[o] = "R1";
        end
        in_valid  = '1;
        in_data   = {NP{16'hA5C3}};
        in_credit = {NP{3'd5}};
        repeat (4) @(negedge clk);
        // R1: outputs and slot held at zero during reset, despite live inputs.
        compare_outputs(0);
        in_valid = '0; in_data = '0; in_credit = '0;
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            compare_outputs(c);
            // Slot closed at the end of cycle c-1: active takes the shadow.
            if (c > 0 && ((c - 1) % 2) == 1)
                for (int o = 0; o < NP; o++)
                    for (int s = 0; s < NS; s++) begin
                        ac_en[o][s] = sh_en[o][s]; ac_src[o][s] = sh_src[o][s];
                    end
            // Expected outputs in cycle c+1 from inputs of c-1 and the slot of c.
            for (int o = 0; o < NP; o++) begin
                int s, src, fan;
                bit pend;
                s = slot_of(c);
                src = ac_src[o][s];
                pend = (sh_en[o][s] != ac_en[o][s]) || (sh_src[o][s] != ac_src[o][s]);
                fan = 0;
                for (int k = 0; k < NP; k++)
                    if (ac_en[k][s] && ac_src[k][s] == src) fan++;
                if (ac_en[o][s]) begin
                    ex_v[o] = pv_v[src]; ex_d[o] = pv_d[src]; ex_c[o] = pv_c[src];
                    if (pend)            ex_tag[o] = "R9";
                    else if (!pv_v[src]) ex_tag[o] = "R8";
                    else if (fan > 1)    ex_tag[o] = "R5";
                    else                 ex_tag[o] = "R4";
                end else begin
                    ex_v[o] = 0; ex_d[o] = '0; ex_c[o] = '0;
                    ex_tag[o] = pend ? "R9" : "R6";
                end
            end
            // Drive inputs for cycle c.
            for (int p = 0; p < NP; p++) begin
                pv_v[p] = (c < 40) ? ((c % 5) != 0) : ($urandom_range(3) != 0);
                pv_d[p] = DW'($urandom);
                pv_c[p] = CW'($urandom);
                in_valid[p]          = pv_v[p];
                in_data[p*DW +: DW]  = pv_d[p];
                in_credit[p*CW +: CW] = pv_c[p];
            end
            pick_write(c, we, wo, ws, wena, wsrc);
            cfg_wr_en = we; cfg_wr_out = 2'(wo); cfg_wr_slot = 3'(ws);
            cfg_wr_enable = wena; cfg_wr_src = 2'(wsrc);
            if (we) begin sh_en[wo][ws] = wena; sh_src[wo][ws] = wsrc; end
            @(posedge clk);
            @(negedge clk);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule